// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block sits between a processor and a small physical memory and turns 14-bit virtual byte addresses into 13-bit physical ones. The upper four address bits select one of sixteen virtual pages, and the lower ten bits are the byte offset inside a 1 KB page. An on-chip table holds one entry per virtual page. Each entry is either absent or gives one of eight 1 KB physical frames.

A translation request is answered one clock later. A present entry yields the frame number placed directly above the unchanged offset. An absent entry yields a fault response with no physical address, so no memory access follows. It also raises an interrupt that names the faulting page. The interrupt is held until software acknowledges it. While it is held, the block refuses new requests.

Software fills and clears the table through a write port. A write changes only the entry of the page it names, and the change is seen from the following cycle. After reset every entry is absent.

Top module: `vpt_translator`

## Requirements
- R1: After reset every table entry is absent, `resp_valid`, `resp_fault` and `fault_irq` are 0, `resp_paddr` and `fault_page` are 0, and `req_ready` is 1.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. Exactly one `resp_valid` pulse follows, in the next cycle. No pulse occurs without an accepted request.
- R3: For a present entry, `resp_paddr` is the 3-bit frame in bits 12:10 and the request's offset bits 9:0 in bits 9:0, with `resp_fault` 0. Example: virtual 0x2442 (page 9, offset 66) with page 9 in frame 2 gives 0x0842.
- R4: For an absent entry, the response has `resp_fault` 1 and `resp_paddr` 0.
- R5: A fault response sets `fault_irq` in the same cycle, with `fault_page` equal to bits 13:10 of the faulting address. Both are held until a cycle with `fault_ack` 1. In the cycle after that, `fault_irq` is 0 and `fault_page` is 0. `fault_ack` has no effect while no fault is pending.
- R6: While `fault_irq` is 1, `req_ready` is 0 and any `req_valid` is ignored: no response follows it.
- R7: A cycle with `cfg_we` 1 and `cfg_valid` 1 makes page `cfg_page` present in frame `cfg_frame`. Requests accepted in later cycles see the new entry. A request accepted in the same cycle sees the old entry.
- R8: A cycle with `cfg_we` 1 and `cfg_valid` 0 makes page `cfg_page` absent, and later requests to that page fault. Writes leave all other pages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual byte address |
| req_ready | output | 1 | Request can be accepted (no fault pending) |
| resp_valid | output | 1 | Response pulse, one cycle after acceptance |
| resp_fault | output | 1 | Response is a page fault |
| resp_paddr | output | 13 | Physical address (0 on fault) |
| fault_irq | output | 1 | Page-fault interrupt, held until acknowledged |
| fault_page | output | 4 | Page number that faulted |
| fault_ack | input | 1 | Software acknowledge of the pending fault |
| cfg_we | input | 1 | Table write strobe |
| cfg_page | input | 4 | Page whose entry is written |
| cfg_valid | input | 1 | 1 installs the entry, 0 makes it absent |
| cfg_frame | input | 3 | Frame number to install |

## Verification
The first request goes to a freshly reset table, so it faults and shows that reset leaves entries absent. The table is then loaded with a scattered mapping, and every page is requested with offsets at both ends of the page and in its middle. This separates frame placement from offset passing, and shows that the right entry is indexed. Directed cases then cover a table write and a request to the same page in one cycle, requests issued while a fault is pending, acknowledges sent with no fault pending, and invalidation of a page that was in use. These show the one-cycle update boundary and the blocking of requests. A long random mix of requests, writes and acknowledges is checked against a behavioural model on every clock. It catches ordering errors between these events.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
    localparam int DEF_VA_W    = 14;
    localparam int DEF_OFF_W   = 10;
    localparam int DEF_FRAME_W = 3;
endpackage

// File: rtl/vpt_table.sv
module vpt_table #(
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic               wr_valid,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [PAGE_W-1:0]  rd_page,
    output logic               rd_valid,
    output logic [FRAME_W-1:0] rd_frame
);
    localparam int ENTRIES = 1 << PAGE_W;

    typedef struct packed {
        logic               present;
        logic [FRAME_W-1:0] frame;
    } slot_t;

    slot_t slot_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slot_t slot_d;

        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_page == PAGE_W'(g))) begin
                slot_d.present = wr_valid;
                if (wr_valid) begin
                    slot_d.frame = wr_frame;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    assign rd_valid = slot_q[rd_page].present;
    assign rd_frame = slot_q[rd_page].frame;
endmodule

// File: rtl/vpt_compose.sv
module vpt_compose #(
    parameter int FRAME_W = 3,
    parameter int OFF_W   = 10
) (
    input  logic                     hit,
    input  logic [FRAME_W-1:0]       frame,
    input  logic [OFF_W-1:0]         offset,
    output logic [FRAME_W+OFF_W-1:0] paddr
);
    always_comb begin
        paddr = '0;
        if (hit) begin
            paddr = {frame, offset};
        end
    end
endmodule

// File: rtl/vpt_translator.sv
module vpt_translator
    import vpt_pkg::*;
#(
    parameter int VA_W    = DEF_VA_W,
    parameter int OFF_W   = DEF_OFF_W,
    parameter int FRAME_W = DEF_FRAME_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          req_vaddr,
    output logic                     req_ready,
    output logic                     resp_valid,
    output logic                     resp_fault,
    output logic [FRAME_W+OFF_W-1:0] resp_paddr,
    output logic                     fault_irq,
    output logic [VA_W-OFF_W-1:0]    fault_page,
    input  logic                     fault_ack,
    input  logic                     cfg_we,
    input  logic [VA_W-OFF_W-1:0]    cfg_page,
    input  logic                     cfg_valid,
    input  logic [FRAME_W-1:0]       cfg_frame
);
    localparam int PAGE_W = VA_W - OFF_W;
    localparam int PA_W   = FRAME_W + OFF_W;

    typedef struct packed {
        logic              resp_valid;
        logic              resp_fault;
        logic [PA_W-1:0]   resp_paddr;
        logic              pend;
        logic [PAGE_W-1:0] fpage;
    } state_t;

    state_t st_d, st_q;

    logic [PAGE_W-1:0]  req_page;
    logic [OFF_W-1:0]   req_off;
    logic               lk_valid;
    logic [FRAME_W-1:0] lk_frame;
    logic [PA_W-1:0]    lk_paddr;
    logic               accept;

    assign req_page = req_vaddr[VA_W-1:OFF_W];
    assign req_off  = req_vaddr[OFF_W-1:0];
    assign accept   = req_valid && !st_q.pend;

    vpt_table #(
        .PAGE_W  (PAGE_W),
        .FRAME_W (FRAME_W)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_page  (cfg_page),
        .wr_valid (cfg_valid),
        .wr_frame (cfg_frame),
        .rd_page  (req_page),
        .rd_valid (lk_valid),
        .rd_frame (lk_frame)
    );

    vpt_compose #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W)
    ) i_compose (
        .hit    (lk_valid),
        .frame  (lk_frame),
        .offset (req_off),
        .paddr  (lk_paddr)
    );

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = accept;
        st_d.resp_fault = accept && !lk_valid;
        st_d.resp_paddr = accept ? lk_paddr : '0;
        if (st_q.pend && fault_ack) begin
            st_d.pend  = 1'b0;
            st_d.fpage = '0;
        end
        if (accept && !lk_valid) begin
            st_d.pend  = 1'b1;
            st_d.fpage = req_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = !st_q.pend;
    assign resp_valid = st_q.resp_valid;
    assign resp_fault = st_q.resp_fault;
    assign resp_paddr = st_q.resp_paddr;
    assign fault_irq  = st_q.pend;
    assign fault_page = st_q.fpage;
endmodule

// File: rtl/vpt_translator_chk.sv
module vpt_translator_chk #(
    parameter int VA_W    = 14,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [VA_W-1:0]          req_vaddr,
    input logic                     req_ready,
    input logic                     resp_valid,
    input logic                     resp_fault,
    input logic [FRAME_W+OFF_W-1:0] resp_paddr,
    input logic                     fault_irq,
    input logic [VA_W-OFF_W-1:0]    fault_page,
    input logic                     fault_ack
);
    AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid); // R2
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (resp_fault || resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R3
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0)); // R4
    AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!resp_fault || (fault_irq && fault_page == $past(req_vaddr[VA_W-1:OFF_W])))); // R5
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_irq && !fault_ack) |=> (fault_irq && $stable(fault_page))); // R5
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_irq && fault_ack) |=> !fault_irq); // R5
    AST_BLOCKED_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_irq && !fault_ack) |=> !req_ready); // R6
endmodule

bind vpt_translator vpt_translator_chk #(
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W)
) i_vpt_translator_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .fault_irq  (fault_irq),
    .fault_page (fault_page),
    .fault_ack  (fault_ack)
);

// File: tb/test_vpt_translator.sv
`timescale 1ns/1ps
module test_vpt_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_fault;
    logic [12:0] resp_paddr;
    logic        fault_irq;
    logic [3:0]  fault_page;
    logic        fault_ack = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_page = '0;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_frame = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    vpt_translator i_vpt_translator (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_paddr (resp_paddr),
        .fault_irq  (fault_irq),
        .fault_page (fault_page),
        .fault_ack  (fault_ack),
        .cfg_we     (cfg_we),
        .cfg_page   (cfg_page),
        .cfg_valid  (cfg_valid),
        .cfg_frame  (cfg_frame)
    );

    // behavioural reference model
    bit m_present [16];
    int m_frame   [16];
    bit e_valid, e_fault, e_pend;
    int e_paddr, e_fpage;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_present[i] = 0;
                m_frame[i]   = 0;
            end
            e_valid = 0; e_fault = 0; e_pend = 0; e_paddr = 0; e_fpage = 0;
        end else begin
            int pg;
            int off;
            bit acc;
            pg  = int'(req_vaddr) / 1024;
            off = int'(req_vaddr) % 1024;
            acc = req_valid && !e_pend;
            e_valid = acc;
            e_fault = acc && !m_present[pg];
            e_paddr = (acc && m_present[pg]) ? m_frame[pg] * 1024 + off : 0;
            if (e_pend && fault_ack) begin
                e_pend  = 0;
                e_fpage = 0;
            end
            if (acc && !m_present[pg]) begin
                e_pend  = 1;
                e_fpage = pg;
            end
            if (cfg_we) begin
                m_present[cfg_page] = cfg_valid;
                if (cfg_valid) m_frame[cfg_page] = int'(cfg_frame);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] at cycle %0d: actual %0d expected %0d", tag, phase, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        chk("R2 resp_valid", int'(resp_valid), int'(e_valid));
        chk("R4 resp_fault", int'(resp_fault), int'(e_fault));
        chk("R3 resp_paddr", int'(resp_paddr), e_paddr);
        chk("R5 fault_irq", int'(fault_irq), int'(e_pend));
        chk("R5 fault_page", int'(fault_page), e_fpage);
        chk("R6 req_ready", int'(req_ready), int'(!e_pend));
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 0; fault_ack = 0; cfg_we = 0;
    endtask

    task automatic request(int va);
        @(negedge clk);
        req_valid = 1; req_vaddr = 14'(va); fault_ack = 0; cfg_we = 0;
    endtask

    task automatic write_entry(int pg, bit pres, int fr);
        @(negedge clk);
        req_valid = 0; fault_ack = 0;
        cfg_we = 1; cfg_page = 4'(pg); cfg_valid = pres; cfg_frame = 3'(fr);
    endtask

    task automatic ack();
        @(negedge clk);
        req_valid = 0; cfg_we = 0; fault_ack = 1;
    endtask

    initial begin
        int map [16];
        int offs [3];
        int unsigned seed;
        map = '{6, -1, -1, 1, -1, 7, 0, -1, -1, 2, -1, 3, -1, -1, 4, 5};
        offs = '{0, 513, 1023};
        seed = 32'h1234_5678;

        // R1: reset state, then a fault on an untouched table
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        request(14'h2442);
        idle();
        idle();
        phase = "R6";
        request(14'h0400);
        request(14'h0800);
        idle();
        phase = "R5";
        ack();
        idle();
        ack();             // no fault pending: no effect
        idle();

        // R7: load the table, R3 sweep
        phase = "R7";
        for (int p = 0; p < 16; p++)
            if (map[p] >= 0) write_entry(p, 1, map[p]);
        phase = "R3";
        request(14'h2442);  // expect 0x0842
        idle();
        for (int p = 0; p < 16; p++)
            for (int k = 0; k < 3; k++) begin
                request(p * 1024 + offs[k]);
                if (e_pend || (map[p] < 0)) begin
                    idle();
                    ack();
                end
            end
        idle();

        // R7: same-cycle write and request sees the old entry
        phase = "R7";
        @(negedge clk);
        req_valid = 1; req_vaddr = 14'(13 * 1024 + 5);
        cfg_we = 1; cfg_page = 4'd13; cfg_valid = 1; cfg_frame = 3'd6;
        idle();
        ack();
        request(13 * 1024 + 5);
        idle();

        // R8: invalidate page 9, neighbours untouched
        phase = "R8";
        write_entry(9, 0, 0);
        request(9 * 1024 + 66);
        request(8 * 1024);     // blocked by pending fault
        idle();
        ack();
        request(11 * 1024 + 7);
        request(15 * 1024 + 1023);
        idle();

        // mixed random traffic
        phase = "MIX";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            seed = seed * 1103515245 + 12345;
            req_valid = seed[20];
            req_vaddr = seed[30:17];
            seed = seed * 1103515245 + 12345;
            cfg_we    = (seed[27:25] == 3'd0);
            cfg_page  = seed[22:19];
            cfg_valid = seed[18];
            cfg_frame = seed[17:15];
            fault_ack = seed[29];
        end
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule